// File: doc/BRIEF.md
# Configurable UART Frame Transceiver

This block sends and receives asynchronous serial frames. Configuration inputs set the frame shape: eight or nine data bits, optional even or odd parity, and either least- or most-significant-bit-first order. In nine-bit mode the top stored bit can act as an address mark. When parity is on, the parity bit is an extra bit on the line that is never stored in the data word. A parallel word with a valid/ready handshake feeds the transmitter. The receiver returns a nine-bit word with a one-cycle valid pulse and parity-error and framing-error flags.

An external 16x oversampling tick sets the timing. Each line bit lasts 16 ticks. The transmit and receive line polarities can each be inverted on their own. A source selector picks the receiver input from one of three places: the receive pin, the transmitter output (internal loop), or the shared transmit pin. The last choice gives half-duplex operation on a single wire. In single-wire mode the transmit driver is enabled only while a frame is on the line.

Top module: `uart_frame_xcvr`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the data bits, then the parity bit when parity is enabled, then one high stop bit. Each bit lasts 16 baud ticks.
- R2: With `cfg_msb_first_i`=0, data bit 0 is sent first, up to bit 7 (eight-bit mode) or bit 8 (nine-bit mode, `cfg_nine_i`=1).
- R3: With `cfg_msb_first_i`=1, eight-bit mode sends bits 7 down to 0. Nine-bit mode sends bit 8 first, then bits 7 down to 0.
- R4: The parity bit comes after all data bits. It makes the count of ones over the stored data bits plus parity even (`cfg_par_odd_i`=0) or odd (`cfg_par_odd_i`=1). In nine-bit mode bit 8 is included. In eight-bit mode `tx_data_i[8]` is ignored and `rx_data_o[8]` is 0.
- R5: `tx_ready_o` is high when idle. A word is taken on a cycle with `tx_valid_i` and `tx_ready_o` both high. `tx_ready_o` then stays low until the stop bit has finished.
- R6: The receiver samples each bit at mid-bit. After the stop bit it pulses `rx_valid_o` for one cycle with the word assembled in the configured order.
- R7: `rx_par_err_o` is high with `rx_valid_o` when parity is enabled and the received parity bit disagrees with the received data.
- R8: `rx_frm_err_o` is high with `rx_valid_o` when the stop bit samples low.
- R9: A low pulse shorter than half a bit on the receive input does not start a frame and produces no `rx_valid_o`.
- R10: With `cfg_loop_i`=1 and `cfg_rx_from_pin_i`=0, the receiver takes its input from `txd_o` and ignores `rxd_i`.
- R11: With `cfg_loop_i`=1 and `cfg_rx_from_pin_i`=1, the receiver takes its input from `txd_pin_i`. `txd_oe_o` is high only while a frame is being sent. In every other mode `txd_oe_o` is 1.
- R12: `cfg_tx_inv_i` inverts `txd_o`, idle level included. `cfg_rx_inv_i` inverts the selected receive source before it reaches the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit |
| cfg_nine_i | input | 1 | 1 selects nine data bits |
| cfg_par_en_i | input | 1 | Parity bit enable |
| cfg_par_odd_i | input | 1 | 1 selects odd parity |
| cfg_msb_first_i | input | 1 | 1 sends the most significant bit first |
| cfg_tx_inv_i | input | 1 | Invert transmit line |
| cfg_rx_inv_i | input | 1 | Invert receive source |
| cfg_loop_i | input | 1 | Disconnect rxd_i from the receiver |
| cfg_rx_from_pin_i | input | 1 | With loop set, receive from txd_pin_i |
| tx_data_i | input | 9 | Word to send |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Transmitter can accept a word |
| rx_data_o | output | 9 | Received word |
| rx_valid_o | output | 1 | One-cycle pulse with a received word |
| rx_par_err_o | output | 1 | Parity mismatch, qualified by rx_valid_o |
| rx_frm_err_o | output | 1 | Stop bit low, qualified by rx_valid_o |
| txd_o | output | 1 | Transmit pin drive value |
| txd_oe_o | output | 1 | Transmit pin driver enable |
| txd_pin_i | input | 1 | Level read back from the transmit pin |
| rxd_i | input | 1 | Receive pin |

## Verification
The start bit appears on `txd_o` on the first clock after the accepting edge. Every bit then lasts exactly 16 ticks, and the bench issues a tick every second clock, so a bit is 32 clocks long. The bench samples transmitted bits 15.5 clocks after acceptance and every 32 clocks after that, which places each sample in the middle of its bit. A received word appears after two synchronizer cycles plus half of the stop bit. Because that arrival time depends on tick phase, the bench waits for the `rx_valid_o` pulse with a bounded timeout and latches the word and flags on that cycle. Absence checks (glitch, isolated `rxd_i`) count valid pulses over a window longer than one whole frame.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
    logic msb_first;
  } frame_cfg_t;
endpackage

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_xcvr_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  frame_cfg_t    cfg_i,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          busy_o,
  output logic          line_o
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OSR);
  localparam int LW = $clog2(FW + 1);

  logic [DW-1:0] dmask, dord;
  logic [FW-1:0] frame, sr_q;
  logic [LW-1:0] flen, left_q;
  logic [CW-1:0] cnt_q;
  logic          par, busy_q;
  int            n;

  always_comb begin
    n     = cfg_i.nine ? DW : DW - 1;
    dmask = data_i;
    if (!cfg_i.nine) dmask[DW-1] = 1'b0;
    dord = dmask;
    if (cfg_i.msb_first) begin
      for (int i = 0; i < DW - 1; i++) dord[i] = cfg_i.nine ? dmask[DW-1-i] : dmask[DW-2-i];
      dord[DW-1] = cfg_i.nine ? dmask[0] : 1'b0;
    end
    par   = (^dmask) ^ cfg_i.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int k = 0; k < DW; k++) if (k < n) frame[k+1] = dord[k];
    if (cfg_i.par_en)
      for (int k = 0; k <= DW; k++) if (k == n) frame[k+1] = par;
    flen = LW'(n + 2 + int'(cfg_i.par_en));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sr_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q <= 1'b1;
        sr_q   <= frame;
        left_q <= flen;
        cnt_q  <= '0;
      end
    end else if (tick_i) begin
      if (cnt_q == CW'(OSR - 1)) begin
        cnt_q  <= '0;
        sr_q   <= {1'b1, sr_q[FW-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == LW'(1)) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ready_o = !busy_q;
  assign busy_o  = busy_q;
  assign line_o  = busy_q ? sr_q[0] : 1'b1;

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> !line_o); // R1
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o); // R5
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_xcvr_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  frame_cfg_t    cfg_i,
  input  logic          line_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          par_err_o,
  output logic          frm_err_o
);
  localparam int CW   = $clog2(OSR);
  localparam int LW   = $clog2(DW + 3);
  localparam int HALF = OSR / 2;

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] idx_q;
  logic [DW-1:0] shf_q;
  logic          par_q;
  int            n, bi;

  always_comb begin
    n  = cfg_i.nine ? DW : DW - 1;
    bi = int'(idx_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shf_q     <= '0;
      par_q     <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: if (!line_i) begin
          state_q <= RX_START;
          cnt_q   <= '0;
        end
        RX_START: if (tick_i) begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shf_q   <= '0;
            state_q <= line_i ? RX_IDLE : RX_BITS; // glitch reject
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_BITS: if (tick_i) begin
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_q <= '0;
            idx_q <= idx_q + 1'b1;
            if (bi < n) begin
              for (int k = 0; k < DW; k++)
                if (k == (cfg_i.msb_first ? n - 1 - bi : bi)) shf_q[k] <= line_i;
            end else if (cfg_i.par_en && bi == n) begin
              par_q <= line_i;
            end else begin
              state_q   <= RX_IDLE;
              valid_o   <= 1'b1;
              data_o    <= shf_q;
              frm_err_o <= !line_i;
              par_err_o <= cfg_i.par_en && ((^shf_q) ^ cfg_i.par_odd ^ par_q);
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_ERR_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o || frm_err_o) |-> valid_o); // R7
  AST_NINE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !cfg_i.nine) |-> !data_o[DW-1]); // R4
endmodule

// File: rtl/uart_frame_xcvr.sv
module uart_frame_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud_tick_i,
  input  logic          cfg_nine_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_odd_i,
  input  logic          cfg_msb_first_i,
  input  logic          cfg_tx_inv_i,
  input  logic          cfg_rx_inv_i,
  input  logic          cfg_loop_i,
  input  logic          cfg_rx_from_pin_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic          rx_par_err_o,
  output logic          rx_frm_err_o,
  output logic          txd_o,
  output logic          txd_oe_o,
  input  logic          txd_pin_i,
  input  logic          rxd_i
);
  frame_cfg_t             cfg;
  logic                   tx_line, tx_busy, rx_src;
  logic [SYNC_STAGES-1:0] sync_q;

  assign cfg = '{nine: cfg_nine_i, par_en: cfg_par_en_i,
                 par_odd: cfg_par_odd_i, msb_first: cfg_msb_first_i};

  uart_tx_core #(.OSR(OSR), .DW(DW)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .cfg_i   (cfg),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .busy_o  (tx_busy),
    .line_o  (tx_line)
  );

  assign txd_o    = tx_line ^ cfg_tx_inv_i;
  assign txd_oe_o = (cfg_loop_i && cfg_rx_from_pin_i) ? tx_busy : 1'b1;

  always_comb begin
    if (!cfg_loop_i)           rx_src = rxd_i;
    else if (cfg_rx_from_pin_i) rx_src = txd_pin_i;
    else                       rx_src = txd_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_src ^ cfg_rx_inv_i};
  end

  uart_rx_core #(.OSR(OSR), .DW(DW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (baud_tick_i),
    .cfg_i     (cfg),
    .line_i    (sync_q[SYNC_STAGES-1]),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .par_err_o (rx_par_err_o),
    .frm_err_o (rx_frm_err_o)
  );

  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_loop_i && cfg_rx_from_pin_i && tx_ready_o) |-> !txd_oe_o); // R11
  AST_OE_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_loop_i |-> txd_oe_o); // R11
endmodule

// File: tb/uart_frame_xcvr_tb_top.sv
module uart_frame_xcvr_tb_top;
  localparam int BIT_CLK = 32; // 16 ticks, one tick every 2 clocks

  typedef struct packed {
    logic       nine;
    logic       pe;
    logic       odd;
    logic       msb;
    logic [8:0] din;
    logic [8:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5, 9'h0A5},
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'h03C, 9'h03C},
    '{1'b0, 1'b1, 1'b1, 1'b1, 9'h0C1, 9'h0C1},
    '{1'b1, 1'b0, 1'b0, 1'b0, 9'h155, 9'h155},
    '{1'b1, 1'b1, 1'b0, 1'b1, 9'h1F0, 9'h1F0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 9'h100, 9'h100},
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'h1FF, 9'h0FF},
    '{1'b1, 1'b0, 1'b0, 1'b1, 9'h001, 9'h001}
  };

  logic clk = 0, rst_n = 0, tick = 0;
  logic c_nine = 0, c_pe = 0, c_odd = 0, c_msb = 0, c_txinv = 0, c_rxinv = 0;
  logic c_loop = 0, c_rsrc = 0;
  logic [8:0] tx_data = '0;
  logic tx_valid = 0, rxd = 1, ext_drv = 1;
  logic tx_ready, rx_valid, rx_perr, rx_ferr, txd, txd_oe, txd_pin;
  logic [8:0] rx_data;

  int n_chk = 0, n_fail = 0, rx_cnt = 0;
  logic [8:0] lat_data;
  logic lat_perr, lat_ferr;
  bit done = 0;

  assign txd_pin = txd_oe ? txd : ext_drv;

  uart_frame_xcvr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick),
    .cfg_nine_i(c_nine), .cfg_par_en_i(c_pe), .cfg_par_odd_i(c_odd),
    .cfg_msb_first_i(c_msb), .cfg_tx_inv_i(c_txinv), .cfg_rx_inv_i(c_rxinv),
    .cfg_loop_i(c_loop), .cfg_rx_from_pin_i(c_rsrc),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_par_err_o(rx_perr),
    .rx_frm_err_o(rx_ferr), .txd_o(txd), .txd_oe_o(txd_oe),
    .txd_pin_i(txd_pin), .rxd_i(rxd)
  );

  always #2.5 clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end

  always @(negedge clk) if (rx_valid) begin
    rx_cnt++;
    lat_data = rx_data;
    lat_perr = rx_perr;
    lat_ferr = rx_ferr;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // expected line frame, built from R1..R4
  function automatic void mk_frame(input logic nine, pe, odd, msb, input logic [8:0] d,
                                   output logic [11:0] f, output int len);
    int n = nine ? 9 : 8;
    logic [8:0] dm = nine ? d : {1'b0, d[7:0]};
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) f[1+i] = msb ? dm[n-1-i] : dm[i];
    if (pe) f[1+n] = (^dm) ^ odd;
    len = n + 2 + int'(pe);
  endfunction

  task automatic set_fmt(input logic nine, pe, odd, msb);
    @(negedge clk);
    c_nine = nine; c_pe = pe; c_odd = odd; c_msb = msb;
  endtask

  // send word, sample txd mid-bit; busy state and OE sampled on the start bit
  task automatic tx_capture(input logic [8:0] d, input int len, output logic [11:0] got,
                            output logic rdy_mid, output logic oe_mid);
    @(negedge clk);
    tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    got = '1;
    repeat (15) @(negedge clk);
    rdy_mid = tx_ready;
    oe_mid  = txd_oe;
    for (int b = 0; b < len; b++) begin
      got[b] = txd;
      if (b < len - 1) repeat (BIT_CLK) @(negedge clk);
    end
  endtask

  task automatic drive_frame(input logic [11:0] f, input int len, input bit on_ext, input bit inv);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      if (on_ext) ext_drv = f[b]; else rxd = f[b] ^ inv;
      repeat (BIT_CLK - 1) @(negedge clk);
    end
    @(negedge clk);
    if (on_ext) ext_drv = 1'b1; else rxd = 1'b1 ^ inv;
  endtask

  task automatic wait_rx(input int base, output bit got);
    got = 0;
    for (int t = 0; t < 1000 && !got; t++) begin
      @(negedge clk);
      if (rx_cnt != base) got = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] f, got;
    int len, base;
    bit ok;
    logic rdy, oe;

    // reset state
    repeat (4) @(negedge clk);
    check(tx_ready === 1'b1, "R5 reset ready", tx_ready, 1);
    check(txd === 1'b1, "R1 reset idle high", txd, 1);
    check(rx_valid === 1'b0, "R6 reset no valid", rx_valid, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // vector table, internal loop (R10)
    c_loop = 1; c_rsrc = 0;
    foreach (VECS[v]) begin
      set_fmt(VECS[v].nine, VECS[v].pe, VECS[v].odd, VECS[v].msb);
      mk_frame(VECS[v].nine, VECS[v].pe, VECS[v].odd, VECS[v].msb, VECS[v].din, f, len);
      base = rx_cnt;
      tx_capture(VECS[v].din, len, got, rdy, oe);
      check(rdy === 1'b0, "R5 ready low mid-frame", rdy, 0);
      check(got === f, VECS[v].msb ? "R3 R1 R4 frame bits" : "R2 R1 R4 frame bits", got, f);
      wait_rx(base, ok);
      check(ok, "R10 loopback word received", ok, 1);
      check(lat_data === VECS[v].exp, "R6 R4 loopback data", lat_data, VECS[v].exp);
      check(!lat_perr && !lat_ferr, "R7 R8 no error flags", {lat_perr, lat_ferr}, 0);
      repeat (BIT_CLK) @(negedge clk);
      check(tx_ready === 1'b1, "R5 ready after stop", tx_ready, 1);
    end

    // receive pin, good frame
    c_loop = 0;
    set_fmt(1, 1, 0, 1);
    mk_frame(1, 1, 0, 1, 9'h12D, f, len);
    base = rx_cnt;
    drive_frame(f, len, 0, 0);
    wait_rx(base, ok);
    check(ok && lat_data === 9'h12D, "R6 pin receive data", lat_data, 9'h12D);
    check(!lat_perr && !lat_ferr, "R6 pin receive clean", {lat_perr, lat_ferr}, 0);

    // parity error (R7)
    f[10] = ~f[10];
    base = rx_cnt;
    drive_frame(f, len, 0, 0);
    wait_rx(base, ok);
    check(ok && lat_perr === 1'b1, "R7 parity error flagged", lat_perr, 1);
    repeat (200) @(negedge clk);

    // framing error (R8)
    set_fmt(0, 0, 0, 0);
    mk_frame(0, 0, 0, 0, 9'h05A, f, len);
    f[9] = 1'b0;
    base = rx_cnt;
    drive_frame(f, len, 0, 0);
    wait_rx(base, ok);
    check(ok && lat_ferr === 1'b1, "R8 framing error flagged", lat_ferr, 1);
    check(lat_data === 9'h05A, "R8 data with framing error", lat_data, 9'h05A);
    repeat (500) @(negedge clk);

    // glitch rejection (R9)
    base = rx_cnt;
    @(negedge clk); rxd = 0;
    repeat (6) @(negedge clk); rxd = 1;
    repeat (500) @(negedge clk);
    check(rx_cnt == base, "R9 glitch ignored", rx_cnt - base, 0);

    // loop isolates rxd_i (R10)
    c_loop = 1; c_rsrc = 0;
    repeat (4) @(negedge clk);
    mk_frame(0, 0, 0, 0, 9'h033, f, len);
    base = rx_cnt;
    drive_frame(f, len, 0, 0);
    repeat (100) @(negedge clk);
    check(rx_cnt == base, "R10 rxd_i ignored in loop", rx_cnt - base, 0);

    // single wire (R11)
    c_rsrc = 1;
    repeat (4) @(negedge clk);
    check(txd_oe === 1'b0, "R11 oe released idle", txd_oe, 0);
    check(txd_pin === 1'b1, "R11 released pin idles high", txd_pin, 1);
    mk_frame(0, 0, 0, 0, 9'h0E7, f, len);
    base = rx_cnt;
    tx_capture(9'h0E7, len, got, rdy, oe);
    check(oe === 1'b1, "R11 oe during frame", oe, 1);
    wait_rx(base, ok);
    check(ok && lat_data === 9'h0E7, "R11 own frame via pin", lat_data, 9'h0E7);
    repeat (BIT_CLK) @(negedge clk);
    check(txd_oe === 1'b0, "R11 oe released after frame", txd_oe, 0);
    mk_frame(0, 0, 0, 0, 9'h018, f, len);
    base = rx_cnt;
    drive_frame(f, len, 1, 0);
    wait_rx(base, ok);
    check(ok && lat_data === 9'h018, "R11 external frame via pin", lat_data, 9'h018);

    // inversion (R12)
    c_loop = 0; c_rsrc = 0;
    @(negedge clk); c_txinv = 1;
    @(negedge clk);
    check(txd === 1'b0, "R12 inverted idle", txd, 0);
    check(txd_oe === 1'b1, "R11 oe set outside single wire", txd_oe, 1);
    mk_frame(0, 0, 0, 0, 9'h081, f, len);
    tx_capture(9'h081, len, got, rdy, oe);
    check(got === ~f[9:0], "R12 inverted tx frame", got[9:0], ~f[9:0]);
    repeat (BIT_CLK) @(negedge clk);
    c_txinv = 0;
    @(negedge clk); rxd = 0; c_rxinv = 1;
    repeat (4) @(negedge clk);
    base = rx_cnt;
    drive_frame(f, len, 0, 1);
    wait_rx(base, ok);
    check(ok && lat_data === 9'h081, "R12 inverted rx frame", lat_data, 9'h081);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule